// File: doc/BRIEF.md
# Single-Wire Half-Duplex Frame Transceiver

This block moves bytes across one open-drain data wire that a pull-up holds high when nobody drives it. Upstream logic offers a byte on a valid/ready stream. The block wraps the byte in a twelve-bit frame and shifts it out by pulling the wire low for every zero bit. It leaves the wire released for every one bit. When the frame is over it stops driving and listens. A falling edge from the far end starts the receiver. The receiver samples each bit near its centre and hands the byte out as a one-cycle strobe, together with a parity flag and a framing flag.

Bit timing comes from a bit-period value measured in system clocks, which an external baud generator supplies. The block copies that value when a frame begins, so a change in the middle of a frame does not disturb it. Only one direction is active at a time. The receiver is gated off while the block transmits, so the block never reads back its own frame.

The transmit stream follows these back-pressure rules. A byte is taken on any clock where `tx_valid` and `tx_ready` are both high. `tx_ready` is low while a frame goes out or comes in. The upstream side must hold `tx_valid` and `tx_data` steady until the byte is taken. The receive side cannot push back, because the wire has no flow control. `rx_data` and the two flags stay valid from the `rx_valid` pulse until the next one. The bit period must be at least 8 clocks.

Top module: `owire_xcvr`

## Requirements
- R1: A transmitted frame has twelve bits, each lasting exactly `bit_period` clocks. The order on the wire is: one low start bit, eight data bits, one parity bit, then two high stop bits.
- R2: Data bits go out and come in least significant bit first.
- R3: The transmitted parity bit is the XOR of the eight data bits, so the nine bits together hold an even count of ones.
- R4: `line_pull_low` is high only during low bits of a frame being sent. The wire is released whenever the block is idle.
- R5: `tx_ready` is low while a frame is being sent or received. The wire is never driven while a frame is being received.
- R6: For a received frame, each bit is sampled half a bit period after the detected start edge plus whole bit periods. One clock after the second stop bit is sampled, `rx_data` shows the byte and `rx_valid` pulses high for a single clock.
- R7: `rx_parity_err` is set when the received data bits and parity bit hold an odd count of ones. The byte is still reported.
- R8: `rx_frame_err` is set when either stop-bit sample is low. The byte is still reported.
- R9: A frame sent by the block never produces an `rx_valid` pulse.
- R10: `bit_period` is captured when a frame begins: at the handshake for transmit, and at the start edge for receive. Later changes do not affect that frame.
- R11: A low pulse that is high again by the start bit's mid-point is dropped, and no byte is reported.
- R12: Each handshake sends exactly one byte. A `tx_valid` held through a busy frame is taken only once the frame has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_period | input | PER_W | Bit duration in clocks, minimum 8 |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Byte can be taken this clock |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-clock strobe for a received byte |
| rx_parity_err | output | 1 | Parity check of the last received byte failed |
| rx_frame_err | output | 1 | A stop bit of the last received byte was low |
| line_in | input | 1 | Level seen on the shared wire |
| line_pull_low | output | 1 | Pull the shared wire low when high |

## Verification
The bench loops the block's own drive back onto the wire it listens to. This catches a receiver that is not gated off during transmit: such a design would report a phantom byte after every send. The bench corrupts the parity bit, the first stop bit and the second stop bit one at a time. A design that drops flagged bytes, or checks only one stop bit, would miss or misreport these cases. It changes `bit_period` part-way through both a sent and a received frame, which exposes a design that reads the live value instead of a copy. It also sends a short low glitch, which exposes a receiver that does not re-check the start bit. It holds `tx_valid` high during a frame and during a received frame, which shows a design that sends twice or drives over the far end.

// File: rtl/owire_pkg.sv
package owire_pkg;
  localparam int unsigned DATA_BITS  = 8;
  localparam int unsigned FRAME_BITS = DATA_BITS + 4;
  localparam int unsigned IDX_W      = $clog2(FRAME_BITS);
  localparam int unsigned RX_KEEP    = FRAME_BITS - 1;

  // even-parity bit over one data byte
  function automatic logic even_par(input logic [DATA_BITS-1:0] d);
    return ^d;
  endfunction
endpackage

// File: rtl/owire_sync.sv
module owire_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= 1'b1;
        else        pipe <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/owire_tx.sv
module owire_tx
  import owire_pkg::*;
#(
  parameter int unsigned PER_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PER_W-1:0]     bit_period,
  input  logic [DATA_BITS-1:0] data,
  input  logic                 start,
  output logic                 busy,
  output logic                 drive_low
);
  logic [FRAME_BITS-1:0] shift;
  logic [PER_W-1:0]      per_q;
  logic [PER_W-1:0]      cnt;
  logic [IDX_W-1:0]      idx;
  logic                  last_tick;

  assign last_tick = busy && (cnt == '0) && (idx == IDX_W'(FRAME_BITS-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      shift <= '1;
      per_q <= '0;
      cnt   <= '0;
      idx   <= '0;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        shift <= {2'b11, even_par(data), data, 1'b0};
        per_q <= bit_period;
        cnt   <= bit_period - 1'b1;
        idx   <= '0;
      end
    end else if (cnt == '0) begin
      if (idx == IDX_W'(FRAME_BITS-1)) begin
        busy  <= 1'b0;
        shift <= '1;
      end else begin
        shift <= {1'b1, shift[FRAME_BITS-1:1]};
        idx   <= idx + 1'b1;
        cnt   <= per_q - 1'b1;
      end
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assign drive_low = busy & ~shift[0];

  // R1: a frame opens with the wire pulled low
  assert_start_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> drive_low);
  // R1: last bit time of a frame is a released stop bit
  assert_stop_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    last_tick |-> !drive_low);
  // R10: captured period holds for the whole frame
  assert_period_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_tick) |=> $stable(per_q));
endmodule

// File: rtl/owire_rx.sv
module owire_rx
  import owire_pkg::*;
#(
  parameter int unsigned PER_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PER_W-1:0]     bit_period,
  input  logic                 line,
  input  logic                 enable,
  output logic                 busy,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 valid,
  output logic                 par_err,
  output logic                 frm_err
);
  logic                 prev;
  logic [PER_W-1:0]     per_q;
  logic [PER_W-1:0]     cnt;
  logic [IDX_W-1:0]     idx;
  logic [RX_KEEP-2:0]   sh;
  logic [RX_KEEP-1:0]   full;

  // current sample joined with the ones already collected
  assign full = {line, sh};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev    <= 1'b1;
      busy    <= 1'b0;
      per_q   <= '0;
      cnt     <= '0;
      idx     <= '0;
      sh      <= '0;
      data_o  <= '0;
      valid   <= 1'b0;
      par_err <= 1'b0;
      frm_err <= 1'b0;
    end else begin
      prev  <= line;
      valid <= 1'b0;
      if (!busy) begin
        if (enable && prev && !line) begin
          busy  <= 1'b1;
          per_q <= bit_period;
          cnt   <= (bit_period >> 1) - 1'b1;
          idx   <= '0;
        end
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        cnt <= per_q - 1'b1;
        if (idx == '0) begin
          if (line) busy <= 1'b0;
          idx <= idx + 1'b1;
        end else begin
          sh <= full[RX_KEEP-1:1];
          if (idx == IDX_W'(FRAME_BITS-1)) begin
            busy    <= 1'b0;
            valid   <= 1'b1;
            data_o  <= full[DATA_BITS-1:0];
            par_err <= ^full[DATA_BITS:0];
            frm_err <= !(full[DATA_BITS+1] && full[DATA_BITS+2]);
          end else begin
            idx <= idx + 1'b1;
          end
        end
      end
    end
  end

  // R6: a received byte is announced for exactly one clock
  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  // R6: the strobe follows the end of a reception
  assert_valid_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> !busy);
endmodule

// File: rtl/owire_xcvr.sv
module owire_xcvr
  import owire_pkg::*;
#(
  parameter int unsigned PER_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PER_W-1:0]     bit_period,
  input  logic [DATA_BITS-1:0] tx_data,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 rx_parity_err,
  output logic                 rx_frame_err,
  input  logic                 line_in,
  output logic                 line_pull_low
);
  logic line_s;
  logic tx_busy;
  logic rx_busy;
  logic tx_fire;
  logic rx_en;

  assign tx_ready = !tx_busy && !rx_busy;
  assign tx_fire  = tx_valid && tx_ready;
  assign rx_en    = !tx_busy && !tx_fire;

  owire_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (line_in),
    .dout (line_s)
  );

  owire_tx #(.PER_W(PER_W)) tx_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_period(bit_period),
    .data      (tx_data),
    .start     (tx_fire),
    .busy      (tx_busy),
    .drive_low (line_pull_low)
  );

  owire_rx #(.PER_W(PER_W)) rx_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_period(bit_period),
    .line      (line_s),
    .enable    (rx_en),
    .busy      (rx_busy),
    .data_o    (rx_data),
    .valid     (rx_valid),
    .par_err   (rx_parity_err),
    .frm_err   (rx_frame_err)
  );

  // R5: no drive while a far-end frame is being received
  assert_quiet_during_rx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_busy |-> !line_pull_low);
  // R9: receiver stays idle through the block's own frame
  assert_no_self_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |-> !rx_busy);
endmodule

// File: tb/owire_xcvr_tb.sv
`timescale 1ns/1ps
module owire_xcvr_tb_top;
  localparam int PER_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [PER_W-1:0] bit_period = 16'd8;
  logic [7:0]       tx_data = 8'h00;
  logic             tx_valid = 1'b0;
  logic             tx_ready;
  logic [7:0]       rx_data;
  logic             rx_valid;
  logic             rx_parity_err;
  logic             rx_frame_err;
  logic             line_pull_low;
  logic             remote_low = 1'b0;
  logic             line_in;

  int checks = 0;
  int errors = 0;
  int rx_cnt = 0;
  logic [7:0] got_data = 8'h00;
  logic       got_pe = 1'b0;
  logic       got_fe = 1'b0;

  always #2.5 clk = ~clk;

  assign line_in = ~(line_pull_low | remote_low);

  owire_xcvr #(.PER_W(PER_W)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_period   (bit_period),
    .tx_data      (tx_data),
    .tx_valid     (tx_valid),
    .tx_ready     (tx_ready),
    .rx_data      (rx_data),
    .rx_valid     (rx_valid),
    .rx_parity_err(rx_parity_err),
    .rx_frame_err (rx_frame_err),
    .line_in      (line_in),
    .line_pull_low(line_pull_low)
  );

  always @(negedge clk) begin
    if (rx_valid) begin
      rx_cnt   <= rx_cnt + 1;
      got_data <= rx_data;
      got_pe   <= rx_parity_err;
      got_fe   <= rx_frame_err;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // offer a byte (call at a negedge); returns right after the accepting edge
  task automatic accept(input logic [7:0] d);
    tx_data  = d;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(posedge clk);
  endtask

  // follow a sent frame bit by bit, starting just after the accepting edge
  task automatic sample_tx(input logic [7:0] d, input int per, input bit keep,
                           input logic [7:0] nxt, input bit chg_per);
    logic [11:0] exp_bits;
    exp_bits = {2'b11, ^d, d, 1'b0};
    for (int c = 0; c < 12 * per; c++) begin
      @(negedge clk);
      if (c == 0) begin
        if (keep) tx_data = nxt;
        else      tx_valid = 1'b0;
        if (chg_per) bit_period = 16'd30;
      end
      if (tx_ready) chk(1'b0, "R12 ready low while sending", 1, 0);
      if (c % per == per / 2)
        chk(line_pull_low == !exp_bits[c / per], "R1 R2 R3 R4 tx bit",
            line_pull_low, !exp_bits[c / per]);
    end
    @(negedge clk);
    chk(tx_ready == 1'b1, "R1 R10 frame length", tx_ready, 1);
    chk(line_pull_low == 1'b0, "R4 released after frame", line_pull_low, 0);
  endtask

  // far end drives one frame starting at a negedge
  task automatic send_remote(input logic [7:0] d, input int per, input bit flip,
                             input bit bad1, input bit bad2);
    logic [11:0] b;
    b = {!bad2, !bad1, (^d) ^ flip, d, 1'b0};
    for (int k = 0; k < 12; k++) begin
      remote_low = !b[k];
      repeat (per) @(negedge clk);
    end
    remote_low = 1'b0;
  endtask

  task automatic rx_case(input string req, input logic [7:0] d, input int per,
                         input bit flip, input bit bad1, input bit bad2);
    int n0;
    n0 = rx_cnt;
    send_remote(d, per, flip, bad1, bad2);
    repeat (per) @(negedge clk);
    chk(rx_cnt == n0 + 1, {req, " one byte"}, rx_cnt - n0, 1);
    chk(got_data == d, {req, " data"}, got_data, d);
    chk(got_pe == flip, {req, " parity flag"}, got_pe, flip);
    chk(got_fe == (bad1 | bad2), {req, " frame flag"}, got_fe, bad1 | bad2);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(tx_ready == 1'b1, "R5 reset ready", tx_ready, 1);
    chk(line_pull_low == 1'b0, "R4 reset released", line_pull_low, 0);
    chk(rx_valid == 1'b0, "R6 reset no strobe", rx_valid, 0);
  endtask

  task automatic t_tx_basic;
    int n0;
    n0 = rx_cnt;
    bit_period = 16'd8;
    @(negedge clk); accept(8'hA5); sample_tx(8'hA5, 8, 1'b0, 8'h00, 1'b0);
    @(negedge clk); accept(8'h01); sample_tx(8'h01, 8, 1'b0, 8'h00, 1'b0);
    bit_period = 16'd9;
    @(negedge clk); accept(8'hFE); sample_tx(8'hFE, 9, 1'b0, 8'h00, 1'b0);
    repeat (10) @(negedge clk);
    chk(rx_cnt == n0, "R9 no self capture", rx_cnt - n0, 0);
  endtask

  task automatic t_tx_period_latch;
    bit_period = 16'd8;
    @(negedge clk); accept(8'h3C); sample_tx(8'h3C, 8, 1'b0, 8'h00, 1'b1);
    bit_period = 16'd8;
  endtask

  task automatic t_tx_backpressure;
    bit_period = 16'd8;
    @(negedge clk); accept(8'h96); sample_tx(8'h96, 8, 1'b1, 8'h4B, 1'b0);
    @(posedge clk); sample_tx(8'h4B, 8, 1'b0, 8'h00, 1'b0);
    repeat (20) @(negedge clk);
    chk(line_pull_low == 1'b0, "R12 single send per handshake", line_pull_low, 0);
  endtask

  task automatic t_rx_good;
    bit_period = 16'd8;
    rx_case("R6 R2 rx 0x00", 8'h00, 8, 1'b0, 1'b0, 1'b0);
    rx_case("R6 R2 rx 0xFF", 8'hFF, 8, 1'b0, 1'b0, 1'b0);
    rx_case("R6 R2 rx 0x81", 8'h81, 8, 1'b0, 1'b0, 1'b0);
    bit_period = 16'd13;
    rx_case("R6 rx odd period", 8'h5A, 13, 1'b0, 1'b0, 1'b0);
    bit_period = 16'd8;
  endtask

  task automatic t_rx_errors;
    bit_period = 16'd10;
    rx_case("R7 parity error", 8'h37, 10, 1'b1, 1'b0, 1'b0);
    rx_case("R8 first stop low", 8'hC4, 10, 1'b0, 1'b1, 1'b0);
    rx_case("R8 second stop low", 8'h2D, 10, 1'b0, 1'b0, 1'b1);
    rx_case("R7 clean after error", 8'h2D, 10, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_rx_period_latch;
    int n0;
    n0 = rx_cnt;
    bit_period = 16'd8;
    fork
      send_remote(8'hB2, 8, 1'b0, 1'b0, 1'b0);
      begin repeat (20) @(negedge clk); bit_period = 16'd31; end
    join
    repeat (8) @(negedge clk);
    chk(rx_cnt == n0 + 1 && got_data == 8'hB2, "R10 rx period latched", got_data, 8'hB2);
    bit_period = 16'd8;
  endtask

  task automatic t_glitch;
    int n0;
    n0 = rx_cnt;
    bit_period = 16'd16;
    @(negedge clk);
    remote_low = 1'b1;
    repeat (2) @(negedge clk);
    remote_low = 1'b0;
    repeat (40) @(negedge clk);
    chk(rx_cnt == n0, "R11 glitch dropped", rx_cnt - n0, 0);
    chk(tx_ready == 1'b1, "R11 receiver idle again", tx_ready, 1);
    rx_case("R11 frame after glitch", 8'h77, 16, 1'b0, 1'b0, 1'b0);
    bit_period = 16'd8;
  endtask

  task automatic t_half_duplex;
    int n0;
    bit seen_ready;
    bit seen_drive;
    n0 = rx_cnt;
    seen_ready = 1'b0;
    seen_drive = 1'b0;
    bit_period = 16'd8;
    fork
      send_remote(8'h6E, 8, 1'b0, 1'b0, 1'b0);
      begin
        repeat (12) @(negedge clk);
        tx_data  = 8'hD3;
        tx_valid = 1'b1;
        repeat (70) begin
          @(negedge clk);
          if (tx_ready) seen_ready = 1'b1;
          if (line_pull_low) seen_drive = 1'b1;
        end
      end
    join
    chk(!seen_ready, "R5 ready low during rx", seen_ready, 0);
    chk(!seen_drive, "R5 no drive during rx", seen_drive, 0);
    chk(rx_cnt == n0 + 1 && got_data == 8'h6E, "R5 rx byte intact", got_data, 8'h6E);
    // pending byte goes out once the line is free
    while (!line_pull_low) @(negedge clk);
    tx_valid = 1'b0;
    repeat (12 * 8) @(negedge clk);
    chk(tx_ready == 1'b1 && rx_cnt == n0 + 1, "R5 R9 deferred send", rx_cnt - n0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_tx_basic();
    t_tx_period_latch();
    t_tx_backpressure();
    t_rx_good();
    t_rx_errors();
    t_rx_period_latch();
    t_glitch();
    t_half_duplex();
    repeat (10) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule